// File: doc/BRIEF.md
# Exception Cause and Status Register Unit

This block keeps the architectural exception state of a 32-bit processor core in one small register file beside the pipeline. When the core raises an exception it pulses a strobe with a 4-bit reason code. In that cycle the unit saves the address of the offending instruction, records the reason, and, for address errors, keeps the data address that failed. It then pushes the processor's kernel/user and interrupt-enable pair onto a three-deep mode stack. A return-from-exception strobe pops that stack.

Five hardware interrupt lines are latched into pending bits that survive while interrupts are masked or disabled. An interrupt request goes out when the current enable bit is set and an unmasked request is pending. Software reads and writes the registers by register number over a simple single-cycle port.

Top module: `exc_status_unit`

## Requirements
- R1: After reset the EPC, bad-address and cause registers read zero and status bits 5:0 read zero. The 8-bit interrupt mask in status bits 15:8 takes the `MASK_RST` value, all ones by default, so status reads 0x0000FF00.
- R2: One cycle after an exception strobe, EPC holds the strobe-cycle PC minus 4. Cause bits 5:2 then hold the strobe's code: 0 external interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 12 overflow. All other cause bits outside the pending field read zero.
- R3: The bad-address register loads the faulting data address only on exceptions with code 4 or 5. Any other code leaves it unchanged, and a software write to it has no effect.
- R4: Status bits 5:0 form three pairs (old 5:4, previous 3:2, current 1:0). Within a pair the upper bit is kernel/user (1 = user) and the lower bit is interrupt enable (1 = enabled). An exception shifts the stack left by two and clears the current pair.
- R5: A return-from-exception strobe shifts the stack right by two and leaves the old pair unchanged. An exception in the same cycle wins, and the return is then ignored.
- R6: Hardware line i (0..4) maps to cause bit 11+i. That bit is set one cycle after the line is seen high. It stays set after the line drops, whatever the mask and enable bits, until it is cleared as in R7.
- R7: A pending bit clears in three cases: software writes 0 to its cause position while the line is low, or the line is low in the cycle after an exception with code 0 was taken while the bit was pending, or the line falls later. Writing 1 never sets a bit, and a high line overrides any clear.
- R8: The interrupt request output is status bit 0 ANDed with the OR, over i, of cause bit 11+i ANDed with mask bit 11+i. Mask bits 10:8 are software levels with no pending source.
- R9: Register numbers for software access are 8 bad address, 12 status, 13 cause and 14 EPC; any other number reads zero. Writes to 14 load EPC, and writes to 12 load bits 15:8 and 5:0, with the other status bits kept at zero. Writes to 13 affect only the pending clears. An exception or return in the same cycle takes precedence over a software write to the registers it updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 1 | Exception taken this cycle |
| exc_code_i | input | 4 | Reason code of the exception |
| pc_i | input | 32 | PC of the core, already advanced by 4 |
| fault_addr_i | input | 32 | Data address involved in the access |
| hw_irq_i | input | 5 | Hardware interrupt lines, level sensitive |
| eret_i | input | 1 | Return-from-exception strobe |
| sw_we_i | input | 1 | Software write enable |
| sw_addr_i | input | 5 | Software register number |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Read data for `sw_addr_i` |
| epc_o | output | 32 | Exception PC |
| cause_o | output | 32 | Cause register |
| badaddr_o | output | 32 | Bad address register |
| status_o | output | 32 | Status register |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed exceptions use each address-error code and a non-address code. The two sets show apart the bad-address capture gate and the EPC and code capture that happens on every exception. Nested exceptions, returns, and an exception coinciding with a return separate push, pop and their priority. For the pending bits, a line is pulsed with the mask closed and then opened, first with enable clear and then set, and later cleared by software or by service. This separates the latching, masking and enable terms of the request. A long run of random strobes, writes and line activity is then compared on every clock against a behavioural reference model, to catch priority mistakes between simultaneous events.

// File: rtl/exc_status_pkg.sv
package exc_status_pkg;
  typedef enum logic [3:0] {
    CODE_EXT_IRQ    = 4'd0,
    CODE_ADDR_LOAD  = 4'd4,
    CODE_ADDR_STORE = 4'd5,
    CODE_IBUS       = 4'd6,
    CODE_DBUS       = 4'd7,
    CODE_SYSCALL    = 4'd8,
    CODE_BREAK      = 4'd9,
    CODE_RESV_INSN  = 4'd10,
    CODE_OVERFLOW   = 4'd12
  } exc_code_e;

  localparam int unsigned REGNO_W = 5;
  localparam logic [REGNO_W-1:0] REGNO_BADADDR = 5'd8;
  localparam logic [REGNO_W-1:0] REGNO_STATUS  = 5'd12;
  localparam logic [REGNO_W-1:0] REGNO_CAUSE   = 5'd13;
  localparam logic [REGNO_W-1:0] REGNO_EPC     = 5'd14;

  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned MASK_LSB = 8;
endpackage

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
  import exc_status_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic              epc_we_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   badaddr_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic addr_fault;
  assign addr_fault = (code_i == CODE_ADDR_LOAD) || (code_i == CODE_ADDR_STORE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o     <= '0;
      badaddr_o <= '0;
      code_o    <= '0;
    end else begin
      if (take_i) begin
        epc_o  <= pc_i - INSN_BYTES; // point back at the faulting instruction
        code_o <= code_i;
        if (addr_fault) badaddr_o <= fault_addr_i;
      end else if (epc_we_i) begin
        epc_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
  parameter int unsigned MASK_W = 8,
  parameter int unsigned LEVELS = 3,
  parameter logic [MASK_W-1:0] MASK_RST = '1,
  localparam int unsigned STK_W = 2 * LEVELS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              we_i,
  input  logic [MASK_W-1:0] wmask_i,
  input  logic [STK_W-1:0]  wstack_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [STK_W-1:0]  stack_o
);
  logic [STK_W-1:0] pushed, popped;

  // pair j of the next stack comes from pair j-1 (push) or j+1 (pop)
  for (genvar j = 0; j < LEVELS; j++) begin : g_pair
    if (j == 0) begin : g_bot
      assign pushed[1:0] = 2'b00;
    end else begin : g_up
      assign pushed[2*j +: 2] = stack_o[2*(j-1) +: 2];
    end
    if (j == LEVELS - 1) begin : g_top
      assign popped[2*j +: 2] = stack_o[2*j +: 2];
    end else begin : g_dn
      assign popped[2*j +: 2] = stack_o[2*(j+1) +: 2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= MASK_RST;
      stack_o <= '0;
    end else begin
      if (push_i)      stack_o <= pushed;
      else if (pop_i)  stack_o <= popped;
      else if (we_i)   stack_o <= wstack_i;
      if (we_i)        mask_o  <= wmask_i;
    end
  end
endmodule

// File: rtl/exc_pend_latch.sv
module exc_pend_latch #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic         service_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] served_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic pend_d, served_d;
    always_comb begin
      if (line_i[g])                   pend_d = 1'b1;
      else if (clr_we_i && !keep_i[g]) pend_d = 1'b0;
      else if (served_q[g])            pend_d = 1'b0;
      else                             pend_d = pend_o[g];
      if (!pend_d)                         served_d = 1'b0;
      else if (service_i && pend_o[g])     served_d = 1'b1;
      else                                 served_d = served_q[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[g]   <= 1'b0;
        served_q[g] <= 1'b0;
      end else begin
        pend_o[g]   <= pend_d;
        served_q[g] <= served_d;
      end
    end
  end
endmodule

// File: rtl/exc_status_unit.sv
module exc_status_unit
  import exc_status_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NUM_HW_IRQ = 5,
  parameter int unsigned NUM_SW_IRQ = 3,
  parameter int unsigned LEVELS     = 3,
  parameter logic [NUM_HW_IRQ+NUM_SW_IRQ-1:0] MASK_RST = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  exc_valid_i,
  input  logic [CODE_W-1:0]     exc_code_i,
  input  logic [XLEN-1:0]       pc_i,
  input  logic [XLEN-1:0]       fault_addr_i,
  input  logic [NUM_HW_IRQ-1:0] hw_irq_i,
  input  logic                  eret_i,
  input  logic                  sw_we_i,
  input  logic [REGNO_W-1:0]    sw_addr_i,
  input  logic [XLEN-1:0]       sw_wdata_i,
  output logic [XLEN-1:0]       sw_rdata_o,
  output logic [XLEN-1:0]       epc_o,
  output logic [XLEN-1:0]       cause_o,
  output logic [XLEN-1:0]       badaddr_o,
  output logic [XLEN-1:0]       status_o,
  output logic                  irq_o
);
  localparam int unsigned MASK_W = NUM_HW_IRQ + NUM_SW_IRQ;
  localparam int unsigned HW_LSB = MASK_LSB + NUM_SW_IRQ;
  localparam int unsigned STK_W  = 2 * LEVELS;

  logic [CODE_W-1:0]     code_q;
  logic [MASK_W-1:0]     mask_q;
  logic [STK_W-1:0]      stack_q;
  logic [NUM_HW_IRQ-1:0] pend_q;
  logic                  wr_epc, wr_status, wr_cause, service;

  assign wr_epc    = sw_we_i && (sw_addr_i == REGNO_EPC);
  assign wr_status = sw_we_i && (sw_addr_i == REGNO_STATUS);
  assign wr_cause  = sw_we_i && (sw_addr_i == REGNO_CAUSE);
  assign service   = exc_valid_i && (exc_code_i == CODE_EXT_IRQ);

  exc_addr_regs #(.XLEN(XLEN)) u_addr (
    .clk_i, .rst_ni,
    .take_i       (exc_valid_i),
    .code_i       (exc_code_i),
    .pc_i,
    .fault_addr_i,
    .epc_we_i     (wr_epc),
    .wdata_i      (sw_wdata_i),
    .epc_o,
    .badaddr_o,
    .code_o       (code_q)
  );

  exc_mode_stack #(.MASK_W(MASK_W), .LEVELS(LEVELS), .MASK_RST(MASK_RST)) u_mode (
    .clk_i, .rst_ni,
    .push_i   (exc_valid_i),
    .pop_i    (eret_i),
    .we_i     (wr_status),
    .wmask_i  (sw_wdata_i[MASK_LSB +: MASK_W]),
    .wstack_i (sw_wdata_i[STK_W-1:0]),
    .mask_o   (mask_q),
    .stack_o  (stack_q)
  );

  exc_pend_latch #(.N(NUM_HW_IRQ)) u_pend (
    .clk_i, .rst_ni,
    .line_i    (hw_irq_i),
    .service_i (service),
    .clr_we_i  (wr_cause),
    .keep_i    (sw_wdata_i[HW_LSB +: NUM_HW_IRQ]),
    .pend_o    (pend_q)
  );

  always_comb begin
    status_o = '0;
    status_o[MASK_LSB +: MASK_W] = mask_q;
    status_o[STK_W-1:0]          = stack_q;
    cause_o = '0;
    cause_o[HW_LSB +: NUM_HW_IRQ] = pend_q;
    cause_o[CODE_LSB +: CODE_W]   = code_q;
  end

  assign irq_o = stack_q[0] && |(pend_q & mask_q[NUM_SW_IRQ +: NUM_HW_IRQ]);

  always_comb begin
    unique case (sw_addr_i)
      REGNO_BADADDR: sw_rdata_o = badaddr_o;
      REGNO_STATUS:  sw_rdata_o = status_o;
      REGNO_CAUSE:   sw_rdata_o = cause_o;
      REGNO_EPC:     sw_rdata_o = epc_o;
      default:       sw_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_status_unit_chk.sv
module exc_status_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exc_valid_i,
  input logic [3:0]  exc_code_i,
  input logic [31:0] pc_i,
  input logic [31:0] fault_addr_i,
  input logic [4:0]  hw_irq_i,
  input logic        eret_i,
  input logic [31:0] epc_o,
  input logic [31:0] cause_o,
  input logic [31:0] badaddr_o,
  input logic [31:0] status_o,
  input logic        irq_o
);
  a_r2_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> epc_o == $past(pc_i) - 32'd4);

  a_r2_code_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> cause_o[5:2] == $past(exc_code_i));

  a_r3_badaddr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && (exc_code_i == 4'd4 || exc_code_i == 4'd5)) |=> badaddr_o == $past(fault_addr_i));

  a_r3_badaddr_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_valid_i && (exc_code_i == 4'd4 || exc_code_i == 4'd5)) |=> $stable(badaddr_o));

  a_r4_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> status_o[5:0] == {$past(status_o[3:0]), 2'b00});

  a_r5_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !exc_valid_i) |=> status_o[5:0] == {$past(status_o[5:4]), $past(status_o[5:2])});

  a_r6_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |hw_irq_i |=> (cause_o[15:11] & $past(hw_irq_i)) == $past(hw_irq_i));

  a_r8_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[0] && (cause_o[15:11] & status_o[15:11]) != 5'd0);
endmodule

bind exc_status_unit exc_status_unit_chk u_chk (
  .clk_i, .rst_ni, .exc_valid_i, .exc_code_i, .pc_i, .fault_addr_i,
  .hw_irq_i, .eret_i, .epc_o, .cause_o, .badaddr_o, .status_o, .irq_o
);

// File: tb/exc_status_unit_test.sv
`timescale 1ns/1ps
module exc_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] pc = '0, fault_addr = '0, wdata = '0;
  logic [4:0]  hw_irq = '0, addr = '0;
  logic        eret = 1'b0, we = 1'b0;
  logic [31:0] rdata, epc, cause, badaddr, status;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [31:0] m_epc, m_bad;
  logic [3:0]  m_code;
  logic [7:0]  m_mask;
  logic [5:0]  m_stk;
  logic [4:0]  m_pend, m_srv;

  always #2.5 clk = ~clk;

  exc_status_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_valid), .exc_code_i(exc_code),
    .pc_i(pc), .fault_addr_i(fault_addr), .hw_irq_i(hw_irq), .eret_i(eret),
    .sw_we_i(we), .sw_addr_i(addr), .sw_wdata_i(wdata), .sw_rdata_o(rdata),
    .epc_o(epc), .cause_o(cause), .badaddr_o(badaddr), .status_o(status), .irq_o(irq)
  );

  function automatic logic [31:0] m_status();
    return {16'h0, m_mask, 2'b00, m_stk};
  endfunction
  function automatic logic [31:0] m_cause();
    return {16'h0, m_pend, 5'b0, m_code, 2'b00};
  endfunction
  function automatic logic m_irq();
    return m_stk[0] && ((m_pend & m_mask[7:3]) != 0);
  endfunction
  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'd8:  return m_bad;
      5'd12: return m_status();
      5'd13: return m_cause();
      5'd14: return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    m_epc = 0; m_bad = 0; m_code = 0; m_mask = 8'hFF; m_stk = 0; m_pend = 0; m_srv = 0;
  endtask

  // next-state of the reference, from the inputs present at this edge
  task automatic m_step();
    logic [4:0] np, ns;
    for (int i = 0; i < 5; i++) begin
      if (hw_irq[i]) np[i] = 1'b1;
      else if (we && addr == 13 && !wdata[11+i]) np[i] = 1'b0;
      else if (m_srv[i]) np[i] = 1'b0;
      else np[i] = m_pend[i];
      if (!np[i]) ns[i] = 1'b0;
      else if (exc_valid && exc_code == 0 && m_pend[i]) ns[i] = 1'b1;
      else ns[i] = m_srv[i];
    end
    if (exc_valid) begin
      m_epc = pc - 4;
      m_code = exc_code;
      if (exc_code == 4 || exc_code == 5) m_bad = fault_addr;
      m_stk = {m_stk[3:0], 2'b00};
    end else begin
      if (we && addr == 14) m_epc = wdata;
      if (eret) m_stk = {m_stk[5:4], m_stk[5:2]};
      else if (we && addr == 12) m_stk = wdata[5:0];
    end
    if (we && addr == 12) m_mask = wdata[15:8];
    m_pend = np; m_srv = ns;
  endtask

  task automatic compare();
    logic [160:0] act, exp;
    act = {epc, cause, badaddr, status, rdata, irq};
    exp = {m_epc, m_cause(), m_bad, m_status(), m_read(addr), m_irq()};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t act epc=%h cause=%h bad=%h st=%h rd=%h irq=%b exp epc=%h cause=%h bad=%h st=%h rd=%h irq=%b",
               tag, $time, epc, cause, badaddr, status, rdata, irq,
               m_epc, m_cause(), m_bad, m_status(), m_read(addr), m_irq());
    end
  endtask

  // drive inputs for one cycle, then compare just after the edge
  task automatic cyc(input logic e, input logic [3:0] c, input logic [31:0] p,
                     input logic [31:0] fa, input logic [4:0] l, input logic r,
                     input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    exc_valid = e; exc_code = c; pc = p; fault_addr = fa; hw_irq = l;
    eret = r; we = w; addr = a; wdata = d;
    @(posedge clk);
    m_step();
    #1 compare();
  endtask

  task automatic idle(input logic [4:0] l, input logic [4:0] a);
    cyc(0, 0, 0, 0, l, 0, 0, a, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 tag = "R1"; compare();
    @(negedge clk) rst_n = 1'b1;
    idle(0, 12); idle(0, 13); idle(0, 8); idle(0, 14); idle(0, 3);

    tag = "R2"; // overflow: not an address error
    cyc(1, 12, 32'h1000, 32'hDEAD0000, 0, 0, 0, 13, 0);
    tag = "R3"; idle(0, 8);
    cyc(1, 4, 32'h2004, 32'h0000ABC1, 0, 0, 0, 8, 0);
    cyc(1, 5, 32'h3008, 32'h0000ABC2, 0, 0, 0, 8, 0);
    cyc(1, 9, 32'h4000, 32'h11111111, 0, 0, 0, 8, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 8, 32'hFFFF_FFFF);   // write to bad address ignored

    tag = "R9";
    cyc(0, 0, 0, 0, 0, 0, 1, 12, 32'hFFFF_FF3F);  // mask all, stack 111111
    cyc(0, 0, 0, 0, 0, 0, 1, 14, 32'h0000_7770);
    cyc(0, 0, 0, 0, 0, 0, 1, 13, 32'h0000_0000);
    cyc(1, 8, 32'h500, 0, 0, 0, 1, 14, 32'h1234);  // exception beats write
    tag = "R4"; cyc(0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_FF27); idle(0, 12);
    cyc(1, 10, 32'h600, 0, 0, 0, 0, 12, 0);
    tag = "R5";
    cyc(0, 0, 0, 0, 0, 1, 0, 12, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 12, 0);
    cyc(1, 6, 32'h700, 0, 0, 1, 0, 12, 0);          // push wins over pop

    tag = "R6";
    cyc(0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_0001);    // mask closed, enabled
    idle(5'b00100, 13); idle(0, 13); idle(0, 13); idle(0, 13);
    tag = "R8";
    cyc(0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_2000);    // mask open, disabled
    cyc(0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_2001);    // enable -> request
    cyc(0, 0, 0, 0, 0, 0, 1, 12, 32'h0000_F801);    // other levels, still set

    tag = "R7";
    cyc(0, 0, 0, 0, 0, 0, 1, 13, 32'h0000_FFFF);    // writing ones changes nothing
    cyc(0, 0, 0, 0, 0, 0, 1, 13, 32'h0000_0000);    // software clear
    idle(0, 13);
    idle(5'b00010, 13); idle(5'b00010, 13);
    cyc(0, 0, 0, 0, 5'b00010, 0, 1, 13, 0);         // line high beats clear
    cyc(1, 0, 32'h800, 0, 5'b00010, 0, 0, 13, 0);   // service while line high
    idle(5'b00010, 13); idle(0, 13); idle(0, 13);
    idle(5'b10000, 13);
    cyc(1, 0, 32'h900, 0, 0, 0, 0, 13, 0);          // service with line low
    idle(0, 13); idle(0, 13);
    idle(5'b01000, 13);
    cyc(1, 7, 32'hA00, 0, 0, 0, 0, 13, 0);          // non-interrupt code: no service
    idle(0, 13); idle(0, 13);

    tag = "R9"; // random mix of all events
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] a;
      a = ($urandom % 4 == 0) ? 5'($urandom) : ((($urandom % 2) == 0) ? 5'd12 : 5'd13);
      cyc(($urandom % 6) == 0, 4'($urandom), $urandom, $urandom, 5'($urandom & $urandom),
          ($urandom % 5) == 0, ($urandom % 4) == 0, a, $urandom);
    end

    tag = "R1";
    @(negedge clk) rst_n = 1'b0;
    m_reset();
    #1 compare();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule